// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the five event flags of one asynchronous serial channel: transmit buffer empty, receive buffer full, receive overrun, framing error and parity error. The transmitter and receiver datapaths raise the flags through single-cycle strobes. Software reads the flags through an 8-bit register port. A DMA engine that moves the channel's data also drops the two buffer flags as a side effect of its transfers.

Software can clear a flag only through a fixed sequence. It first reads the register while the flag is 1. Its next write, with a 0 in that flag's bit, then clears the flag. A write of 0 that follows no such read leaves the flag alone, so a flag raised after the last read cannot be lost by mistake. A standby input returns every flag to its reset value.

Top module: `serial_status_flags`

## Requirements
- R1: After reset, and in the cycle after any cycle with `standby_i` high, the register reads 0x80: transmit-empty is 1 and the other four flags are 0. Bits 2..0 always read 0.
- R2: Transmit-empty (bit 7) becomes 1 in the cycle after a `tx_load_i` pulse, and while `tx_en_i` is low.
- R3: A `dma_tx_wr_i` pulse clears transmit-empty when no event that sets it occurs in the same cycle.
- R4: Receive-full (bit 6) becomes 1 after a `rx_done_i` pulse that has neither error strobe and arrives while receive-full is 0. A frame that carries an error does not set it.
- R5: A `dma_rx_rd_i` pulse clears receive-full.
- R6: A `rx_done_i` pulse that arrives while receive-full is 1 sets overrun (bit 5) and leaves receive-full at 1.
- R7: A `rx_done_i` pulse together with `rx_frame_err_i` sets framing error (bit 4). Together with `rx_par_err_i` it sets parity error (bit 3).
- R8: A register read that returns a flag at 1 arms that flag. The next register write clears every armed flag whose write-data bit is 0.
- R9: A write of 0 to a flag that has not been armed leaves the flag at 1. Every register write disarms all flags, including a write that clears nothing.
- R10: Writing 1 to a flag bit has no effect on the flag.
- R11: When a set event and a clearing write hit the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous standby; forces the reset values |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current flags: bits 7..3, with bits 2..0 at 0 |
| tx_en_i | input | 1 | Transmitter enable level |
| tx_load_i | input | 1 | Transmit data moved into the shift register |
| dma_tx_wr_i | input | 1 | DMA wrote the transmit data register |
| rx_done_i | input | 1 | End of a received frame |
| rx_frame_err_i | input | 1 | Frame at `rx_done_i` had a bad stop bit |
| rx_par_err_i | input | 1 | Frame at `rx_done_i` had a parity mismatch |
| dma_rx_rd_i | input | 1 | DMA read the receive data register |

## Verification
The embedded properties assume every event input is a single-cycle strobe. They also assume that a register read and a register write never arrive in the same cycle, because the arming rule does not define an order between them. The bench drives each strobe for one cycle from the falling edge and never pairs a read with a write. The error strobes are only driven together with `rx_done_i`. The bench raises `standby_i` only for a single cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam int NF    = 5;
  localparam int F_TXE = 4;
  localparam int F_RXF = 3;
  localparam int F_OVR = 2;
  localparam int F_FER = 1;
  localparam int F_PER = 0;

  localparam logic [NF-1:0] FLAG_RST = 5'b10000;

  // Next flag value: a set event has priority over any clear.
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic hw_clr, input logic sw_clr);
    return set | (q & ~hw_clr & ~sw_clr);
  endfunction

  // Arming latch: any write or a zero flag disarms; a read seeing 1 arms.
  function automatic logic arm_next(input logic armed, input logic q,
                                    input logic rd, input logic wr);
    if (wr || !q) return 1'b0;
    if (rd)       return 1'b1;
    return armed;
  endfunction

endpackage

// File: rtl/sts_flag_cell.sv
module sts_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o,
  output logic armed_o
);
  import sts_pkg::*;

  logic q_q;
  logic armed_q;
  logic sw_clr_w;

  assign sw_clr_w = armed_q & wr_i & ~wbit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q     <= RST_VAL;
      armed_q <= 1'b0;
    end else if (force_i) begin
      q_q     <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      q_q     <= flag_next(q_q, set_i, hw_clr_i, sw_clr_w);
      armed_q <= arm_next(armed_q, q_q, rd_i, wr_i);
    end
  end

  assign q_o     = q_q;
  assign armed_o = armed_q;

  // R11: a set event is never lost to a clear in the same cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !force_i) |=> q_o);

  // R9: without arming and without a hardware clear, a set flag stays set
  a_r9_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !armed_o && !hw_clr_i && !force_i) |=> q_o);

  // R8: an armed flag written with 0 clears when nothing sets it
  a_r8_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && wr_i && !wbit_i && !set_i && !force_i) |=> !q_o);

  // R10: writing 1 never clears a flag
  a_r10_one_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && wr_i && wbit_i && !hw_clr_i && !force_i) |=> q_o);

  // R8: the latch is armed only by a read that saw the flag at 1
  a_r8_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(rd_i && q_o));

endmodule

// File: rtl/sts_event_decode.sv
module sts_event_decode (
  input  logic                  tx_en_i,
  input  logic                  tx_load_i,
  input  logic                  dma_tx_wr_i,
  input  logic                  rx_done_i,
  input  logic                  rx_frame_err_i,
  input  logic                  rx_par_err_i,
  input  logic                  dma_rx_rd_i,
  input  logic                  rxf_i,
  output logic [sts_pkg::NF-1:0] set_o,
  output logic [sts_pkg::NF-1:0] hw_clr_o
);
  import sts_pkg::*;

  logic rx_err_w;
  logic rx_good_w;
  logic ovr_evt_w;

  assign rx_err_w  = rx_frame_err_i | rx_par_err_i;
  assign rx_good_w = rx_done_i & ~rx_err_w & ~rxf_i;
  assign ovr_evt_w = rx_done_i & rxf_i;

  always_comb begin
    set_o           = '0;
    hw_clr_o        = '0;
    set_o[F_TXE]    = ~tx_en_i | tx_load_i;
    set_o[F_RXF]    = rx_good_w;
    set_o[F_OVR]    = ovr_evt_w;
    set_o[F_FER]    = rx_done_i & rx_frame_err_i;
    set_o[F_PER]    = rx_done_i & rx_par_err_i;
    hw_clr_o[F_TXE] = dma_tx_wr_i;
    hw_clr_o[F_RXF] = dma_rx_rd_i;
  end

endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             tx_en_i,
  input  logic             tx_load_i,
  input  logic             dma_tx_wr_i,
  input  logic             rx_done_i,
  input  logic             rx_frame_err_i,
  input  logic             rx_par_err_i,
  input  logic             dma_rx_rd_i
);
  import sts_pkg::*;

  localparam int LSB_POS = REG_W - NF;

  logic [NF-1:0] flags_w;
  logic [NF-1:0] armed_w;
  logic [NF-1:0] set_w;
  logic [NF-1:0] hw_clr_w;

  sts_event_decode u_decode (
    .tx_en_i        (tx_en_i),
    .tx_load_i      (tx_load_i),
    .dma_tx_wr_i    (dma_tx_wr_i),
    .rx_done_i      (rx_done_i),
    .rx_frame_err_i (rx_frame_err_i),
    .rx_par_err_i   (rx_par_err_i),
    .dma_rx_rd_i    (dma_rx_rd_i),
    .rxf_i          (flags_w[F_RXF]),
    .set_o          (set_w),
    .hw_clr_o       (hw_clr_w)
  );

  for (genvar i = 0; i < NF; i++) begin : g_flag
    sts_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_i  (standby_i),
      .set_i    (set_w[i]),
      .hw_clr_i (hw_clr_w[i]),
      .rd_i     (reg_rd_i),
      .wr_i     (reg_wr_i),
      .wbit_i   (reg_wdata_i[LSB_POS+i]),
      .q_o      (flags_w[i]),
      .armed_o  (armed_w[i])
    );
  end

  assign reg_rdata_o = {flags_w, {LSB_POS{1'b0}}};

  // R1: standby returns the register to its reset image
  a_r1_standby_image: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (reg_rdata_o == {1'b1, {(REG_W-1){1'b0}}}));

  // R2: loading the shifter or disabling the transmitter marks it empty
  a_r2_txe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_i || tx_load_i) |=> flags_w[F_TXE]);

  // R3: a DMA write to transmit data clears empty when nothing sets it
  a_r3_dma_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_wr_i && tx_en_i && !tx_load_i && !standby_i) |=> !flags_w[F_TXE]);

  // R5: a DMA read of receive data drops receive-full
  a_r5_dma_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_rd_i && !rx_done_i && !standby_i) |=> !flags_w[F_RXF]);

  // R6: a frame ending while receive-full is held raises overrun
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && flags_w[F_RXF] && !standby_i) |=> flags_w[F_OVR]);

  // R9: no flag is still armed after a register write
  a_r9_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (armed_w == '0));

endmodule

// File: tb/serial_status_flags_tb.sv
module serial_status_flags_tb_top;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       tx_en_i = 1'b0;
  logic       tx_load_i = 1'b0;
  logic       dma_tx_wr_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic       rx_frame_err_i = 1'b0;
  logic       rx_par_err_i = 1'b0;
  logic       dma_rx_rd_i = 1'b0;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  serial_status_flags dut_i (.*);

  // end the current cycle: wait for the falling edge, then drop all strobes
  task automatic tick();
    @(negedge clk);
    reg_rd_i = 0; reg_wr_i = 0; tx_load_i = 0; dma_tx_wr_i = 0;
    rx_done_i = 0; rx_frame_err_i = 0; rx_par_err_i = 0; dma_rx_rd_i = 0;
    standby_i = 0;
  endtask

  task automatic expect_read(input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    reg_rd_i = 1;
    tick();
  endtask

  task automatic reg_write(input logic [7:0] d);
    reg_wr_i = 1; reg_wdata_i = d;
    tick();
  endtask

  // monitor: compare every read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (reg_rd_i) begin
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read: actual %02h expected none", reg_rdata_o);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (reg_rdata_o !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, reg_rdata_o, it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tx_en_i = 1;
    tick();
    // R9: write 0 without a previous read at 1 keeps transmit-empty
    reg_write(8'h00);
    expect_read(8'h80, "R1 reset image / R9 unarmed write");
    // R10: writing ones changes nothing; this write also disarms
    reg_write(8'hFF);
    expect_read(8'h80, "R10 write ones");
    reg_write(8'hFF);
    reg_write(8'h00);
    expect_read(8'h80, "R9 disarmed by earlier write");
    // R8: read at 1 then write 0 clears
    reg_write(8'h7F);
    expect_read(8'h00, "R8 txe cleared");
    // R2 / R3
    tx_load_i = 1; tick();
    expect_read(8'h80, "R2 tx_load sets txe");
    dma_tx_wr_i = 1; tick();
    expect_read(8'h00, "R3 dma write clears txe");
    tx_en_i = 0; tick();
    tx_en_i = 1;
    expect_read(8'h80, "R2 tx disable sets txe");
    dma_tx_wr_i = 1; tick();
    expect_read(8'h00, "R3 dma write clears txe again");
    // R7 / R4: error frames set error flags, not receive-full
    rx_done_i = 1; rx_frame_err_i = 1; tick();
    expect_read(8'h10, "R7 framing / R4 no rxf on error");
    rx_done_i = 1; rx_par_err_i = 1; tick();
    expect_read(8'h18, "R7 parity");
    reg_write(8'hE7);
    expect_read(8'h00, "R8 error flags cleared");
    // R4 / R6 / R5
    rx_done_i = 1; tick();
    expect_read(8'h40, "R4 good frame sets rxf");
    rx_done_i = 1; tick();
    expect_read(8'h60, "R6 overrun keeps rxf");
    dma_rx_rd_i = 1; tick();
    expect_read(8'h20, "R5 dma read clears rxf");
    reg_write(8'h00);
    expect_read(8'h00, "R8 overrun cleared");
    // R11: set and clearing write in one cycle
    tx_load_i = 1; tick();
    expect_read(8'h80, "R2 txe set before race");
    tx_load_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h00; tick();
    expect_read(8'h80, "R11 set wins over clear");
    // R1: standby restores reset image
    rx_done_i = 1; tick();
    expect_read(8'hC0, "R4 rxf before standby");
    standby_i = 1; tick();
    expect_read(8'h80, "R1 standby image");
    repeat (3) tick();
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule